// File: doc/BRIEF.md
# Multi-Rail Reset and Status Controller

This block turns a set of already-digitized undervoltage flags, one per supply rail, into a per-rail active-low status output and a single active-low system reset. The reset drops whenever any rail is low, when a glitch-filtered manual reset is held low, or when a watchdog expiry event arrives. It is released only after a programmable quiet period during which no fault of any kind is seen. A supply-lockout flag overrides everything and pulls every output low.

A margin mode is provided for supply margining tests. While the margin input is held low, and after a settling delay, all outputs are parked at their inactive (high) level and frozen. A watchdog expiry that arrives while outputs are parked is remembered, and it is applied at the moment the outputs are released again. All timing is in clock cycles. The timeout comes either from a parameter or from a configuration input selected at run time. Every asynchronous input passes through a two-stage synchronizer.

Top module: `multi_rail_rst_ctl`

## Requirements
- R1: Each `rail_no[i]` is low while `uv_i[i]` is 1 and high while it is 0. Outside lockout and margin, the output follows the input two clock edges after a change, with no stretching.
- R2: `sys_rst_no` goes low three clock edges after any rail flag rises, or after `wdog_i` rises. A watchdog expiry is a 0-to-1 transition of the synchronized `wdog_i`.
- R3: Once every fault source is clear, `sys_rst_no` stays low for exactly the timeout length in clock cycles, counted from the first edge at which the internal stretcher sees no fault. It then goes high.
- R4: With `tmo_sel_i` = 1 the timeout length is `tmo_cfg_i` cycles, with a value of 0 treated as 1. With `tmo_sel_i` = 0 the length is the `TIMEOUT_CYC` parameter.
- R5: A new fault that arrives while the timeout is counting restarts the full timeout once that fault clears.
- R6: A low on `mr_ni` that lasts fewer than `GLITCH_CYC` cycles does not affect `sys_rst_no`. A low of `GLITCH_CYC` cycles or more asserts reset, and release follows R3 once `mr_ni` returns high.
- R7: While `lockout_i` is 1, `sys_rst_no` and every `rail_no` bit are 0, even in margin mode. After lockout ends, a full timeout runs.
- R8: `MARGIN_CYC` cycles after the synchronized `margin_ni` changes, margin mode is entered or left. While in margin mode (and not in lockout), all outputs are 1 and stay constant whatever the rail flags do.
- R9: A watchdog expiry that arrives during margin mode does not change the outputs. It asserts `sys_rst_no` at the same edge at which margin mode ends, and release then follows R3.
- R10: While `srst_ni` is low, `sys_rst_no` is 0. After `srst_ni` rises, `sys_rst_no` stays low for exactly the selected timeout, provided the inputs are idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| srst_ni | input | 1 | Synchronous active-low reset of the logic |
| uv_i | input | N_RAILS | Undervoltage flag per rail, 1 = below threshold |
| mr_ni | input | 1 | Manual reset request, active low, asynchronous |
| lockout_i | input | 1 | Supply lockout, 1 forces all outputs low |
| margin_ni | input | 1 | Margin request, active low |
| wdog_i | input | 1 | Watchdog expiry level, a rising edge is one event |
| tmo_sel_i | input | 1 | 1 selects the runtime timeout value |
| tmo_cfg_i | input | TMO_W | Runtime timeout length in cycles |
| rail_no | output | N_RAILS | Per-rail status, active low |
| sys_rst_no | output | 1 | System reset, active low |

## Verification
The embedded properties assume that `tmo_sel_i` and `tmo_cfg_i` are held steady while a timeout is counting. They also assume that `wdog_i` is a level whose rising edges mark expiries, and that the raw inputs are free of metastability once past the synchronizers. The stimulus changes every input only on falling clock edges and changes the configuration only while no timeout is running. Each watchdog event is a single-cycle high level, and margin entry is always allowed to settle before the rails or the watchdog are exercised underneath it.

// File: rtl/rsc_pkg.sv
// Shared definitions for the multi-rail reset controller.
// Assumes: control inputs are bundled so they share one synchronizer.
package rsc_pkg;

    localparam int SYNC_DEPTH = 2;

    // Control inputs that share a synchronizer bank
    typedef struct packed {
        logic mr_n;
        logic lock;
        logic margin_n;
        logic wdog;
    } ctl_t;

    // Idle (no request) level of every control input
    localparam ctl_t CTL_IDLE = '{mr_n: 1'b1, lock: 1'b0, margin_n: 1'b1, wdog: 1'b0};

    // Cycles needed to cover a duration in ns, rounded up by one cycle
    function automatic int cycles_from_ns(input int hz, input int ns);
        return (hz / 1_000_000) * ns / 1000 + 1;
    endfunction

endpackage

// File: rtl/rsc_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous inputs.
// Assumes: each bit is independent; bundle coherence is not required.
module rsc_sync
    import rsc_pkg::*;
#(
    parameter int W = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk_i,
    input  logic         srst_ni,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stg_q [SYNC_DEPTH];

    // Shift the raw value through the synchronizer stages
    always_ff @(posedge clk_i) begin
        if (!srst_ni) begin
            for (int s = 0; s < SYNC_DEPTH; s++) stg_q[s] <= RST_VAL;
        end else begin
            stg_q[0] <= d_i;
            for (int s = 1; s < SYNC_DEPTH; s++) stg_q[s] <= stg_q[s-1];
        end
    end

    assign q_o = stg_q[SYNC_DEPTH-1];

endmodule

// File: rtl/rsc_low_filter.sv
// Rejects short lows on an active-low request: the filtered output drops
// only after HOLD_CYC consecutive low samples, and rises at once on a high.
// Assumes: raw_ni is already synchronized.
module rsc_low_filter #(
    parameter int HOLD_CYC = 4
) (
    input  logic clk_i,
    input  logic srst_ni,
    input  logic raw_ni,
    output logic filt_no
);

    localparam int CW = $clog2(HOLD_CYC + 1);

    logic [CW-1:0] cnt_q;
    logic          filt_q;

    // Count consecutive low samples; assert once the run is long enough
    always_ff @(posedge clk_i) begin
        if (!srst_ni) begin
            cnt_q  <= '0;
            filt_q <= 1'b1;
        end else if (raw_ni) begin
            cnt_q  <= '0;
            filt_q <= 1'b1;
        end else if (filt_q) begin
            if (cnt_q == CW'(HOLD_CYC - 1)) filt_q <= 1'b0;
            else                            cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign filt_no = filt_q;

    // R6: the filtered request can only fall after a low raw sample
    a_r6_filter_needs_low: assert property (@(posedge clk_i) disable iff (!srst_ni)
        $fell(filt_q) |-> !$past(raw_ni));

endmodule

// File: rtl/rsc_margin_ctl.sv
// Margin mode control: follows the margin request after DELAY_CYC stable
// cycles and keeps any watchdog expiry seen while outputs are parked, so it
// can be released on the edge at which margin mode ends.
// Assumes: margin_ni and wd_pulse_i are synchronized; wd_pulse_i is one cycle.
module rsc_margin_ctl #(
    parameter int DELAY_CYC = 6
) (
    input  logic clk_i,
    input  logic srst_ni,
    input  logic margin_ni,
    input  logic wd_pulse_i,
    output logic hold_o,
    output logic wd_fire_o
);

    localparam int CW = $clog2(DELAY_CYC + 1);

    logic [CW-1:0] cnt_q;
    logic          hold_q;
    logic          pend_q;
    logic          want;
    logic          differ;
    logic          flip;
    logic          exit_now;

    // Decide whether the parked state is about to change this edge
    always_comb begin
        want     = !margin_ni;
        differ   = want != hold_q;
        flip     = differ && (cnt_q == CW'(DELAY_CYC - 1));
        exit_now = flip && hold_q;
    end

    // Settle the margin state after the request has been steady long enough
    always_ff @(posedge clk_i) begin
        if (!srst_ni) begin
            hold_q <= 1'b0;
            cnt_q  <= '0;
        end else if (!differ) begin
            cnt_q <= '0;
        end else if (flip) begin
            hold_q <= want;
            cnt_q  <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Remember a watchdog expiry that arrives while outputs are parked
    always_ff @(posedge clk_i) begin
        if (!srst_ni)                  pend_q <= 1'b0;
        else if (exit_now)             pend_q <= 1'b0;
        else if (hold_q && wd_pulse_i) pend_q <= 1'b1;
    end

    assign hold_o    = hold_q;
    assign wd_fire_o = (wd_pulse_i && !hold_q) || (exit_now && (pend_q || wd_pulse_i));

    // R8: the parked state only ever moves toward the requested state
    a_r8_flip_follows_request: assert property (@(posedge clk_i) disable iff (!srst_ni)
        (hold_q != $past(hold_q)) |-> (hold_q == !$past(margin_ni)));

    // R9: a pending expiry is only captured while parked
    a_r9_pend_only_parked: assert property (@(posedge clk_i) disable iff (!srst_ni)
        $rose(pend_q) |-> $past(hold_q));

endmodule

// File: rtl/rsc_stretch.sv
// Reset stretcher: drives reset low on any fault and releases it after a
// fault-free run of the selected length. Any fault restarts the count.
// Assumes: sel_i and cfg_i are steady while a count is running.
module rsc_stretch #(
    parameter int TIMEOUT_CYC = 20,
    parameter int TMO_W       = 8
) (
    input  logic             clk_i,
    input  logic             srst_ni,
    input  logic             fault_i,
    input  logic             sel_i,
    input  logic [TMO_W-1:0] cfg_i,
    output logic             rst_no
);

    logic [TMO_W-1:0] cnt_q;
    logic [TMO_W-1:0] limit;
    logic             rst_n_q;

    // Pick the timeout length, never allowing a zero-length run
    always_comb begin
        if (sel_i) limit = (cfg_i == '0) ? TMO_W'(1) : cfg_i;
        else       limit = TMO_W'(TIMEOUT_CYC);
    end

    // Clear on fault, count quiet cycles, release at the limit
    always_ff @(posedge clk_i) begin
        if (!srst_ni) begin
            cnt_q   <= '0;
            rst_n_q <= 1'b0;
        end else if (fault_i) begin
            cnt_q   <= '0;
            rst_n_q <= 1'b0;
        end else if (!rst_n_q) begin
            if (cnt_q == limit - 1'b1) rst_n_q <= 1'b1;
            else                       cnt_q   <= cnt_q + 1'b1;
        end
    end

    assign rst_no = rst_n_q;

    // R2: a fault always holds reset on the following cycle
    a_r2_fault_holds_reset: assert property (@(posedge clk_i) disable iff (!srst_ni)
        fault_i |=> !rst_n_q);

    // R3: release only happens after a cycle without fault
    a_r3_release_after_quiet: assert property (@(posedge clk_i) disable iff (!srst_ni)
        $rose(rst_n_q) |-> !$past(fault_i));

endmodule

// File: rtl/multi_rail_rst_ctl.sv
// Multi-rail reset and status controller top. Synchronizes the rail flags
// and control inputs, filters manual reset, handles margin parking and the
// reset timeout, and applies lockout with top priority.
// Assumes: uv_i bits are 1 for an undervoltage; wdog_i rises once per expiry.
module multi_rail_rst_ctl
    import rsc_pkg::*;
#(
    parameter int N_RAILS     = 4,
    parameter int CLK_HZ      = 50_000_000,
    parameter int TIMEOUT_CYC = CLK_HZ / 1000 * 140,
    parameter int GLITCH_CYC  = cycles_from_ns(CLK_HZ, 100),
    parameter int MARGIN_CYC  = CLK_HZ / 50_000,
    parameter int TMO_W       = 24
) (
    input  logic               clk_i,
    input  logic               srst_ni,
    input  logic [N_RAILS-1:0] uv_i,
    input  logic               mr_ni,
    input  logic               lockout_i,
    input  logic               margin_ni,
    input  logic               wdog_i,
    input  logic               tmo_sel_i,
    input  logic [TMO_W-1:0]   tmo_cfg_i,
    output logic [N_RAILS-1:0] rail_no,
    output logic               sys_rst_no
);

    localparam int CTL_W = $bits(ctl_t);

    logic [N_RAILS-1:0] uv_s;
    ctl_t               ctl_raw;
    ctl_t               ctl_s;
    logic               mr_filt_n;
    logic               wd_d_q;
    logic               wd_pulse;
    logic               hold;
    logic               wd_fire;
    logic               fault;
    logic               stretch_rst_n;

    assign ctl_raw = '{mr_n: mr_ni, lock: lockout_i, margin_n: margin_ni, wdog: wdog_i};

    rsc_sync #(.W(N_RAILS), .RST_VAL('0)) i_uv_sync (
        .clk_i  (clk_i),
        .srst_ni(srst_ni),
        .d_i    (uv_i),
        .q_o    (uv_s)
    );

    rsc_sync #(.W(CTL_W), .RST_VAL(CTL_IDLE)) i_ctl_sync (
        .clk_i  (clk_i),
        .srst_ni(srst_ni),
        .d_i    (ctl_raw),
        .q_o    (ctl_s)
    );

    rsc_low_filter #(.HOLD_CYC(GLITCH_CYC)) i_mr_filt (
        .clk_i  (clk_i),
        .srst_ni(srst_ni),
        .raw_ni (ctl_s.mr_n),
        .filt_no(mr_filt_n)
    );

    // Delay the synchronized watchdog level to find its rising edge
    always_ff @(posedge clk_i) begin
        if (!srst_ni) wd_d_q <= 1'b0;
        else          wd_d_q <= ctl_s.wdog;
    end

    assign wd_pulse = ctl_s.wdog && !wd_d_q;

    rsc_margin_ctl #(.DELAY_CYC(MARGIN_CYC)) i_margin (
        .clk_i     (clk_i),
        .srst_ni   (srst_ni),
        .margin_ni (ctl_s.margin_n),
        .wd_pulse_i(wd_pulse),
        .hold_o    (hold),
        .wd_fire_o (wd_fire)
    );

    // Collect every condition that must hold the system in reset
    always_comb begin
        fault = (|uv_s) || !mr_filt_n || wd_fire || ctl_s.lock;
    end

    rsc_stretch #(.TIMEOUT_CYC(TIMEOUT_CYC), .TMO_W(TMO_W)) i_stretch (
        .clk_i  (clk_i),
        .srst_ni(srst_ni),
        .fault_i(fault),
        .sel_i  (tmo_sel_i),
        .cfg_i  (tmo_cfg_i),
        .rst_no (stretch_rst_n)
    );

    // Per-rail status drivers with lockout and margin overrides
    for (genvar g = 0; g < N_RAILS; g++) begin : g_rail
        always_comb begin
            if (ctl_s.lock) rail_no[g] = 1'b0;
            else if (hold)  rail_no[g] = 1'b1;
            else            rail_no[g] = !uv_s[g];
        end
    end

    // System reset driver with the same override order
    always_comb begin
        if (ctl_s.lock) sys_rst_no = 1'b0;
        else if (hold)  sys_rst_no = 1'b1;
        else            sys_rst_no = stretch_rst_n;
    end

    // R7: lockout always restarts the timeout in the stretcher
    a_r7_lock_restarts: assert property (@(posedge clk_i) disable iff (!srst_ni)
        ctl_s.lock |=> !stretch_rst_n);

    // R8: outputs are frozen while parked and outside lockout
    a_r8_parked_frozen: assert property (@(posedge clk_i) disable iff (!srst_ni)
        (hold && $past(hold) && !ctl_s.lock && !$past(ctl_s.lock))
            |-> ($stable(sys_rst_no) && $stable(rail_no)));

endmodule

// File: tb/test_multi_rail_rst_ctl.sv
module test_multi_rail_rst_ctl;

    localparam int CLK_PERIOD = 10;
    localparam int N  = 4;
    localparam int L  = 20;
    localparam int G  = 4;
    localparam int M  = 6;
    localparam int TW = 8;
    localparam logic [N-1:0] ALL = '1;

    logic          clk = 1'b0;
    logic          srst_n;
    logic [N-1:0]  uv;
    logic          mr_n, lock, margin_n, wdog, sel;
    logic [TW-1:0] cfg;
    logic [N-1:0]  rail_n;
    logic          rst_n;

    typedef struct {
        int unsigned  at;
        logic         rst;
        logic [N-1:0] rails;
        string        tag;
    } exp_t;

    exp_t        sb_q[$];
    int unsigned cyc = 0;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    multi_rail_rst_ctl #(
        .N_RAILS(N), .TIMEOUT_CYC(L), .GLITCH_CYC(G), .MARGIN_CYC(M), .TMO_W(TW)
    ) i_multi_rail_rst_ctl (
        .clk_i(clk), .srst_ni(srst_n), .uv_i(uv), .mr_ni(mr_n), .lockout_i(lock),
        .margin_ni(margin_n), .wdog_i(wdog), .tmo_sel_i(sel), .tmo_cfg_i(cfg),
        .rail_no(rail_n), .sys_rst_no(rst_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Driver side: queue an expected output state a number of edges ahead
    task automatic expect_at(input int unsigned dly, input logic r,
                             input logic [N-1:0] rl, input string tag);
        sb_q.push_back('{cyc + dly, r, rl, tag});
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: pop due items and compare away from the active edge
    always @(negedge clk) begin
        while (sb_q.size() > 0 && sb_q[0].at <= cyc) begin
            exp_t e;
            e = sb_q.pop_front();
            n_chk++;
            if (e.at != cyc || rst_n !== e.rst || rail_n !== e.rails) begin
                n_fail++;
                $display("FAIL %s @%0d: rst=%b rails=%b expected rst=%b rails=%b",
                         e.tag, cyc, rst_n, rail_n, e.rst, e.rails);
            end
        end
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            finish_run();
        end
    end

    initial begin
        srst_n = 1'b0; uv = '0; mr_n = 1'b1; lock = 1'b0; margin_n = 1'b1;
        wdog = 1'b0; sel = 1'b0; cfg = '0;
        settle(3);
        // R10: reset state while the logic is held in reset
        expect_at(1, 1'b0, ALL, "R10 held in reset");
        settle(2);
        srst_n = 1'b1;
        expect_at(L - 1, 1'b0, ALL, "R10 still in timeout");
        expect_at(L,     1'b1, ALL, "R10 released after timeout");
        settle(L + 2);

        // R1, R2, R3: single rail fault and release
        uv = 4'b0100;
        expect_at(1, 1'b1, ALL,     "R1 not yet visible");
        expect_at(2, 1'b1, 4'b1011, "R1 rail low");
        expect_at(3, 1'b0, 4'b1011, "R2 reset on rail");
        settle(6);
        uv = '0;
        expect_at(2,     1'b0, ALL, "R1 rail back high");
        expect_at(L + 1, 1'b0, ALL, "R3 held for timeout");
        expect_at(L + 2, 1'b1, ALL, "R3 released");
        settle(L + 4);

        // R1, R5: two rails, then a short new fault during the countdown
        uv = 4'b1001;
        expect_at(2, 1'b1, 4'b0110, "R1 two rails low");
        expect_at(3, 1'b0, 4'b0110, "R2 reset on two rails");
        settle(5);
        uv = '0;
        expect_at(2, 1'b0, ALL, "R1 rails recovered");
        settle(8);
        uv = 4'b0001;
        expect_at(2, 1'b0, 4'b1110, "R1 short fault visible");
        settle(1);
        uv = '0;
        expect_at(2,     1'b0, ALL, "R1 no stretch");
        expect_at(L + 1, 1'b0, ALL, "R5 timeout restarted");
        expect_at(L + 2, 1'b1, ALL, "R5 release after restart");
        settle(L + 4);

        // R6: short manual reset low is ignored
        mr_n = 1'b0;
        settle(G - 1);
        mr_n = 1'b1;
        for (int k = 1; k <= G + 6; k++) expect_at(k, 1'b1, ALL, "R6 short low ignored");
        settle(G + 8);

        // R6: long enough manual reset asserts and then times out
        mr_n = 1'b0;
        expect_at(G + 2, 1'b1, ALL, "R6 before filter");
        expect_at(G + 3, 1'b0, ALL, "R6 manual reset asserted");
        settle(G + 5);
        mr_n = 1'b1;
        expect_at(L + 2, 1'b0, ALL, "R6 held for timeout");
        expect_at(L + 3, 1'b1, ALL, "R6 released");
        settle(L + 5);

        // R2: watchdog expiry
        wdog = 1'b1;
        settle(1);
        wdog = 1'b0;
        expect_at(1,     1'b1, ALL, "R2 wdog not yet");
        expect_at(2,     1'b0, ALL, "R2 wdog reset");
        expect_at(L + 1, 1'b0, ALL, "R3 wdog held");
        expect_at(L + 2, 1'b1, ALL, "R3 wdog released");
        settle(L + 4);

        // R4: runtime timeout of 8 cycles
        sel = 1'b1; cfg = 8'd8;
        uv = 4'b0001;
        expect_at(3, 1'b0, 4'b1110, "R4 fault");
        settle(4);
        uv = '0;
        expect_at(9,  1'b0, ALL, "R4 runtime held");
        expect_at(10, 1'b1, ALL, "R4 runtime released");
        settle(12);

        // R4: zero runtime value acts as one cycle
        cfg = '0;
        uv = 4'b0001;
        settle(1);
        uv = '0;
        expect_at(1, 1'b1, 4'b1110, "R4 zero fault visible");
        expect_at(2, 1'b0, ALL,     "R4 zero reset");
        expect_at(3, 1'b1, ALL,     "R4 zero one-cycle release");
        settle(5);
        sel = 1'b0;

        // R8: margin entry over an active fault
        uv = 4'b0010;
        settle(4);
        margin_n = 1'b0;
        expect_at(M + 1, 1'b0, 4'b1101, "R8 before margin delay");
        expect_at(M + 2, 1'b1, ALL,     "R8 parked high");
        settle(M + 3);
        uv = 4'b1111;
        expect_at(3, 1'b1, ALL, "R8 rails ignored");
        expect_at(5, 1'b1, ALL, "R8 still frozen");
        settle(6);
        uv = '0;
        settle(L + 4);

        // R9: watchdog during margin is held
        wdog = 1'b1;
        settle(1);
        wdog = 1'b0;
        expect_at(3, 1'b1, ALL, "R9 expiry held in margin");
        settle(5);

        // R7: lockout overrides margin
        lock = 1'b1;
        expect_at(2, 1'b0, '0, "R7 lockout over margin");
        settle(3);
        lock = 1'b0;
        expect_at(2, 1'b1, ALL, "R7 back to parked");
        settle(L + 4);

        // R9: held expiry applied when margin ends
        margin_n = 1'b1;
        expect_at(M + 1,     1'b1, ALL, "R9 still parked");
        expect_at(M + 2,     1'b0, ALL, "R9 expiry applied at exit");
        expect_at(M + 1 + L, 1'b0, ALL, "R9 held for timeout");
        expect_at(M + 2 + L, 1'b1, ALL, "R9 released");
        settle(M + L + 5);

        // R7: lockout in normal mode
        lock = 1'b1;
        uv = 4'b0100;
        expect_at(1, 1'b1, ALL, "R7 not yet");
        expect_at(2, 1'b0, '0,  "R7 all low");
        settle(3);
        lock = 1'b0;
        uv = '0;
        expect_at(2,     1'b0, ALL, "R7 rails back");
        expect_at(L + 1, 1'b0, ALL, "R7 timeout after lockout");
        expect_at(L + 2, 1'b1, ALL, "R7 released");
        settle(L + 4);

        done = 1'b1;
        finish_run();
    end

endmodule